// File: doc/BRIEF.md
# SPI FIFO Status and Interrupt Unit

This block holds the status flags and the interrupt-enable register of a memory-mapped SPI controller. The controller has one transmit FIFO and one receive FIFO of 32-bit words. The block watches both FIFOs through their empty and full indications and their push, pop and flush strobes. It also takes an overflow event and an end-of-transfer event. From these it builds an 8-bit status word and one level-sensitive interrupt line.

Six status flags are level flags. They are recomputed at every clock edge. Four of them come straight from the empty and full indications. The other two are watermark flags, taken from occupancy counters that the block keeps from the push and pop strobes. The overflow flag and the transfer-complete flag are sticky. Software clears each one by writing a 1 to its position through the status write port.

The interrupt line is high whenever any status bit that has its enable bit set is high. Every flag is registered, so the interrupt responds one clock after the event that caused it.

Top module: `spi_fifo_stat_irq`

## Requirements
- R1: While `rst_n` is low at a clock edge, the status word becomes 8'h03 (only bits 0 and 1 set), the enable register becomes 0 and `irq_o` is low.
- R2: Unless a transmit flush is active, bit 0 takes the value `tx_empty_i` had at the previous edge and bit 2 takes the value of `tx_full_i`.
- R3: Unless a receive flush is active, bit 3 takes the inverse of `rx_empty_i` from the previous edge and bit 5 takes `rx_full_i`.
- R4: Bit 1 is set when the transmit occupancy after the edge is at most `TX_LOW_MARK`. The occupancy is counted from 0 as follows: a push is taken when the count is below `FIFO_DEPTH`, a pop is taken when the count is above 0, and both are evaluated on the count before the edge.
- R5: Bit 4 is set when the receive occupancy after the edge, counted by the same rule, is at least `RX_HIGH_MARK`.
- R6: Bit 6 becomes set after an edge at which `ovf_evt_i` is high, or at which `rx_push_i` and `rx_full_i` are both high. It then stays set until it is cleared.
- R7: Bit 7 becomes set after an edge at which `xfer_done_i` is high, and stays set until it is cleared.
- R8: A write with `wr_sel_i` = 0 clears bit 6 and bit 7 where `wr_data_i` has a 1, leaves them unchanged where it has a 0, and has no effect on bits 0 to 5. If a set event and a clear write reach the same flag in one cycle, the set wins.
- R9: A write with `wr_sel_i` = 1 loads `wr_data_i` into the enable register, which is shown on `int_en_o` one cycle later.
- R10: `irq_o` is high exactly when the bitwise AND of `status_o` and `int_en_o` is non-zero.
- R11: After an edge with `tx_flush_i` high, bit 0 is 1, bit 2 is 0 and the transmit occupancy is 0, so bit 1 is 1. This holds whatever the transmit inputs were at that edge.
- R12: After an edge with `rx_flush_i` high, bits 3, 4, 5 and 6 are 0 and the receive occupancy is 0. This holds even when an overflow event arrives at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tx_empty_i | input | 1 | Transmit FIFO holds no word |
| tx_full_i | input | 1 | Transmit FIFO is full |
| tx_push_i | input | 1 | Word written into the transmit FIFO |
| tx_pop_i | input | 1 | Word taken from the transmit FIFO |
| tx_flush_i | input | 1 | Transmit FIFO reset pulse |
| rx_empty_i | input | 1 | Receive FIFO holds no word |
| rx_full_i | input | 1 | Receive FIFO is full |
| rx_push_i | input | 1 | Word arriving at the receive FIFO |
| rx_pop_i | input | 1 | Word read from the receive FIFO |
| rx_flush_i | input | 1 | Receive FIFO reset pulse |
| ovf_evt_i | input | 1 | Receive overflow event |
| xfer_done_i | input | 1 | Transfer completion event |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | Write target: 0 status (clear on 1), 1 interrupt enable |
| wr_data_i | input | 8 | Write data |
| status_o | output | 8 | Status word |
| int_en_o | output | 8 | Interrupt-enable register |
| irq_o | output | 1 | Level interrupt request |

## Verification
A wrong occupancy counter does not show up at once. It stays hidden until the count crosses a watermark, and then bit 1 or bit 4 flips at the wrong edge, possibly many cycles after the push or pop that was missed. For that reason the reference model tracks both counts and is compared on every cycle.

A wrong sticky flag shows up one edge after the faulty set, clear or flush. It appears on `status_o`, and on `irq_o` too when its enable bit is set. The directed cases look at the collisions: a set meeting a clear write in the same cycle, and a flush meeting an overflow event.

// File: rtl/spi_stat_pkg.sv
// Shared constants for the SPI FIFO status unit.
// Bit positions are decoded by software, so their order is fixed.
package spi_stat_pkg;
    localparam int STAT_W        = 8;
    localparam int BIT_TX_EMPTY  = 0;
    localparam int BIT_TX_LOW    = 1;
    localparam int BIT_TX_FULL   = 2;
    localparam int BIT_RX_AVAIL  = 3;
    localparam int BIT_RX_HIGH   = 4;
    localparam int BIT_RX_FULL   = 5;
    localparam int BIT_RX_OVF    = 6;
    localparam int BIT_XFER_DONE = 7;
    localparam logic [STAT_W-1:0] STAT_RESET = 8'h03;

    typedef enum logic {
        SEL_STATUS = 1'b0,
        SEL_ENABLE = 1'b1
    } reg_sel_e;
endpackage

// File: rtl/spi_fifo_level.sv
// Occupancy tracker for one FIFO, with a watermark compare.
// Assumes push and pop are single-cycle strobes, one word each.
// A push is ignored when the FIFO is full and a pop is ignored when it
// is empty; both are judged on the count before the edge.
// MARK_IS_CEILING selects the compare: "count <= MARK" or "count >= MARK".
module spi_fifo_level #(
    parameter int DEPTH           = 64,
    parameter int MARK            = 16,
    parameter bit MARK_IS_CEILING = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic push_i,
    input  logic pop_i,
    input  logic flush_i,
    output logic mark_hit_o
);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] MARK_C  = CNT_W'(MARK);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_next;
    logic             push_ok;
    logic             pop_ok;

    // Next occupancy from the accepted strobes; a flush overrides both.
    always_comb begin
        push_ok  = push_i && (cnt_q != DEPTH_C);
        pop_ok   = pop_i && (cnt_q != '0);
        cnt_next = flush_i ? '0 : (cnt_q + CNT_W'(push_ok) - CNT_W'(pop_ok));
    end

    // Occupancy register.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_next;
    end

    // Watermark compare on the next count, so the flag can be registered
    // in the same edge as the count.
    generate
        if (MARK_IS_CEILING) begin : g_ceiling
            assign mark_hit_o = (cnt_next <= MARK_C);
        end else begin : g_floor
            assign mark_hit_o = (cnt_next >= MARK_C);
        end
    endgenerate

    assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= DEPTH_C);

    assert_flush_empty_R11_R12: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> (cnt_q == '0));

    assert_push_grows_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !pop_i && !flush_i && cnt_q != DEPTH_C) |=> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/spi_sticky_flag.sv
// One sticky status flag that software clears by writing a 1.
// Priority, highest first: flush (forces 0), then set event, then clear write.
// Assumes every input is synchronous to clk.
module spi_sticky_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    input  logic flush_i,
    output logic flag_o
);
    // Sticky state update.
    always_ff @(posedge clk) begin
        if (!rst_n)       flag_o <= 1'b0;
        else if (flush_i) flag_o <= 1'b0;
        else if (set_i)   flag_o <= 1'b1;
        else if (clr_i)   flag_o <= 1'b0;
    end

    assert_flag_set_R6_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i && !flush_i) |=> flag_o);

    assert_flag_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && !clr_i && !flush_i) |=> flag_o);

    assert_flag_no_spurious_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_o && !set_i) |=> !flag_o);
endmodule

// File: rtl/spi_fifo_stat_irq.sv
// Status and interrupt unit for an SPI controller with a transmit FIFO
// and a receive FIFO.
// Level flags are registered from the FIFO indications and from occupancy
// counts kept here. The overflow and done flags are sticky and are cleared
// by writing a 1. irq_o is the OR of all enabled status bits.
// Assumes all inputs are synchronous to clk and that strobes are
// single-cycle.
module spi_fifo_stat_irq
    import spi_stat_pkg::*;
#(
    parameter int FIFO_DEPTH   = 64,
    parameter int TX_LOW_MARK  = 16,
    parameter int RX_HIGH_MARK = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_empty_i,
    input  logic              tx_full_i,
    input  logic              tx_push_i,
    input  logic              tx_pop_i,
    input  logic              tx_flush_i,
    input  logic              rx_empty_i,
    input  logic              rx_full_i,
    input  logic              rx_push_i,
    input  logic              rx_pop_i,
    input  logic              rx_flush_i,
    input  logic              ovf_evt_i,
    input  logic              xfer_done_i,
    input  logic              wr_en_i,
    input  logic              wr_sel_i,
    input  logic [STAT_W-1:0] wr_data_i,
    output logic [STAT_W-1:0] status_o,
    output logic [STAT_W-1:0] int_en_o,
    output logic              irq_o
);
    reg_sel_e    sel;
    logic        wr_status;
    logic        wr_enable;
    logic        tx_low_hit;
    logic        rx_high_hit;
    logic        te_q, tf_q, tlow_q, rr_q, rf_q, rhigh_q;
    logic        ovf_flag, done_flag;
    logic        ovf_set;
    logic [STAT_W-1:0] ien_q;

    // Decode the write target.
    always_comb begin
        sel       = reg_sel_e'(wr_sel_i);
        wr_status = wr_en_i && (sel == SEL_STATUS);
        wr_enable = wr_en_i && (sel == SEL_ENABLE);
        ovf_set   = ovf_evt_i || (rx_push_i && rx_full_i);
    end

    spi_fifo_level #(
        .DEPTH(FIFO_DEPTH), .MARK(TX_LOW_MARK), .MARK_IS_CEILING(1'b1)
    ) u_tx_level (
        .clk(clk), .rst_n(rst_n), .push_i(tx_push_i), .pop_i(tx_pop_i),
        .flush_i(tx_flush_i), .mark_hit_o(tx_low_hit)
    );

    spi_fifo_level #(
        .DEPTH(FIFO_DEPTH), .MARK(RX_HIGH_MARK), .MARK_IS_CEILING(1'b0)
    ) u_rx_level (
        .clk(clk), .rst_n(rst_n), .push_i(rx_push_i), .pop_i(rx_pop_i),
        .flush_i(rx_flush_i), .mark_hit_o(rx_high_hit)
    );

    // Transmit level flags; a flush forces the empty pattern.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            te_q   <= 1'b1;
            tf_q   <= 1'b0;
            tlow_q <= 1'b1;
        end else begin
            te_q   <= tx_flush_i ? 1'b1 : tx_empty_i;
            tf_q   <= tx_flush_i ? 1'b0 : tx_full_i;
            tlow_q <= tx_low_hit;
        end
    end

    // Receive level flags; a flush clears them.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rr_q    <= 1'b0;
            rf_q    <= 1'b0;
            rhigh_q <= 1'b0;
        end else begin
            rr_q    <= rx_flush_i ? 1'b0 : !rx_empty_i;
            rf_q    <= rx_flush_i ? 1'b0 : rx_full_i;
            rhigh_q <= rx_high_hit;
        end
    end

    spi_sticky_flag u_ovf_flag (
        .clk(clk), .rst_n(rst_n), .set_i(ovf_set),
        .clr_i(wr_status && wr_data_i[BIT_RX_OVF]),
        .flush_i(rx_flush_i), .flag_o(ovf_flag)
    );

    spi_sticky_flag u_done_flag (
        .clk(clk), .rst_n(rst_n), .set_i(xfer_done_i),
        .clr_i(wr_status && wr_data_i[BIT_XFER_DONE]),
        .flush_i(1'b0), .flag_o(done_flag)
    );

    // Interrupt-enable register.
    always_ff @(posedge clk) begin
        if (!rst_n)         ien_q <= '0;
        else if (wr_enable) ien_q <= wr_data_i;
    end

    // Assemble the status word at its fixed bit positions.
    always_comb begin
        status_o                = '0;
        status_o[BIT_TX_EMPTY]  = te_q;
        status_o[BIT_TX_LOW]    = tlow_q;
        status_o[BIT_TX_FULL]   = tf_q;
        status_o[BIT_RX_AVAIL]  = rr_q;
        status_o[BIT_RX_HIGH]   = rhigh_q;
        status_o[BIT_RX_FULL]   = rf_q;
        status_o[BIT_RX_OVF]    = ovf_flag;
        status_o[BIT_XFER_DONE] = done_flag;
    end

    // Interrupt and enable outputs.
    assign int_en_o = ien_q;
    assign irq_o    = |(status_o & ien_q);

    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> (status_o == STAT_RESET && int_en_o == '0 && !irq_o));

    assert_tx_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_flush_i |=> (status_o[BIT_TX_EMPTY] == $past(tx_empty_i)
                      && status_o[BIT_TX_FULL] == $past(tx_full_i)));

    assert_rx_follow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_flush_i |=> (status_o[BIT_RX_AVAIL] == !$past(rx_empty_i)
                      && status_o[BIT_RX_FULL] == $past(rx_full_i)));

    assert_enable_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_enable |=> (int_en_o == $past(wr_data_i)));

    assert_tx_flush_R11: assert property (@(posedge clk) disable iff (!rst_n)
        tx_flush_i |=> (status_o[BIT_TX_EMPTY] && !status_o[BIT_TX_FULL]
                     && status_o[BIT_TX_LOW]));

    assert_rx_flush_R12: assert property (@(posedge clk) disable iff (!rst_n)
        rx_flush_i |=> (!status_o[BIT_RX_AVAIL] && !status_o[BIT_RX_FULL]
                     && !status_o[BIT_RX_HIGH] && !status_o[BIT_RX_OVF]));

    assert_irq_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (int_en_o == '0) |-> !irq_o);
endmodule

// File: tb/spi_fifo_stat_irq_tb.sv
// Bench for spi_fifo_stat_irq: a behavioural reference model is updated
// at every rising edge and compared against the outputs at the falling edge.
module spi_fifo_stat_irq_tb_top;
    import spi_stat_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 8;
    localparam int TX_LOW     = 2;
    localparam int RX_HIGH    = 5;
    localparam int MAX_CYC    = 200000;

    logic clk, rst_n;
    logic tx_empty, tx_full, tx_push, tx_pop, tx_flush;
    logic rx_empty, rx_full, rx_push, rx_pop, rx_flush;
    logic ovf_evt, xfer_done, wr_en, wr_sel;
    logic [7:0] wr_data, status, int_en;
    logic irq;

    int         m_tx, m_rx;
    logic [7:0] m_stat, m_ien;
    int         checks = 0;
    int         fails  = 0;
    bit         done   = 0;

    spi_fifo_stat_irq #(
        .FIFO_DEPTH(DEPTH), .TX_LOW_MARK(TX_LOW), .RX_HIGH_MARK(RX_HIGH)
    ) dut_i (
        .clk(clk), .rst_n(rst_n),
        .tx_empty_i(tx_empty), .tx_full_i(tx_full), .tx_push_i(tx_push),
        .tx_pop_i(tx_pop), .tx_flush_i(tx_flush),
        .rx_empty_i(rx_empty), .rx_full_i(rx_full), .rx_push_i(rx_push),
        .rx_pop_i(rx_pop), .rx_flush_i(rx_flush),
        .ovf_evt_i(ovf_evt), .xfer_done_i(xfer_done),
        .wr_en_i(wr_en), .wr_sel_i(wr_sel), .wr_data_i(wr_data),
        .status_o(status), .int_en_o(int_en), .irq_o(irq)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    // Reference model, built from the requirements.
    always @(posedge clk) begin
        int ntx, nrx;
        bit pa, pp;
        logic [7:0] s;
        if (!rst_n) begin
            m_stat = 8'h03; m_ien = 8'h00; m_tx = 0; m_rx = 0;
        end else begin
            pa  = tx_push && m_tx < DEPTH;
            pp  = tx_pop && m_tx > 0;
            ntx = tx_flush ? 0 : m_tx + int'(pa) - int'(pp);
            pa  = rx_push && m_rx < DEPTH;
            pp  = rx_pop && m_rx > 0;
            nrx = rx_flush ? 0 : m_rx + int'(pa) - int'(pp);
            s = m_stat;
            s[0] = tx_flush ? 1'b1 : tx_empty;
            s[2] = tx_flush ? 1'b0 : tx_full;
            s[1] = (ntx <= TX_LOW);
            s[3] = rx_flush ? 1'b0 : !rx_empty;
            s[5] = rx_flush ? 1'b0 : rx_full;
            s[4] = (nrx >= RX_HIGH);
            if (rx_flush) s[6] = 1'b0;
            else if (ovf_evt || (rx_push && rx_full)) s[6] = 1'b1;
            else if (wr_en && !wr_sel && wr_data[6]) s[6] = 1'b0;
            if (xfer_done) s[7] = 1'b1;
            else if (wr_en && !wr_sel && wr_data[7]) s[7] = 1'b0;
            if (wr_en && wr_sel) m_ien = wr_data;
            m_stat = s; m_tx = ntx; m_rx = nrx;
        end
    end

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic string bit_req(input int b);
        case (b)
            0, 2:    return "R2";
            1:       return "R4";
            3, 5:    return "R3";
            4:       return "R5";
            6:       return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic compare_all();
        for (int b = 0; b < 8; b++) chk(bit_req(b), $sformatf("status bit %0d", b), 32'(status[b]), 32'(m_stat[b]));
        chk("R9", "int_en", 32'(int_en), 32'(m_ien));
        chk("R10", "irq", 32'(irq), 32'(|(m_stat & m_ien)));
    endtask

    task automatic quiet();
        tx_push = 0; tx_pop = 0; tx_flush = 0; rx_push = 0; rx_pop = 0; rx_flush = 0;
        ovf_evt = 0; xfer_done = 0; wr_en = 0; wr_sel = 0; wr_data = 8'h00;
        tx_empty = (m_tx == 0); tx_full = (m_tx == DEPTH);
        rx_empty = (m_rx == 0); rx_full = (m_rx == DEPTH);
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        compare_all();
        quiet();
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        repeat (MAX_CYC) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL R1 watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        m_tx = 0; m_rx = 0;
        quiet();
        repeat (3) step();
        // R1: reset state
        chk("R1", "status after reset", 32'(status), 32'h03);
        chk("R1", "int_en after reset", 32'(int_en), 32'h00);
        chk("R1", "irq after reset", 32'(irq), 32'h0);
        rst_n = 1'b1;

        // Mixed traffic in phases that alternate between filling and draining.
        for (int i = 0; i < 3000; i++) begin
            int up;
            up = ((i / 150) % 2 == 0) ? 75 : 25;
            tx_push   = ($urandom_range(99) < up);
            tx_pop    = ($urandom_range(99) < 100 - up);
            rx_push   = ($urandom_range(99) < up);
            rx_pop    = ($urandom_range(99) < 100 - up);
            tx_flush  = ($urandom_range(99) < 2);
            rx_flush  = ($urandom_range(99) < 2);
            ovf_evt   = ($urandom_range(99) < 2);
            xfer_done = ($urandom_range(99) < 4);
            wr_en     = ($urandom_range(99) < 8);
            wr_sel    = 1'($urandom_range(1));
            wr_data   = 8'($urandom_range(255));
            step();
        end

        // R9 and R10: enable the done bit only, then raise it.
        wr_en = 1; wr_sel = 1; wr_data = 8'h80; step();
        chk("R9", "int_en loaded", 32'(int_en), 32'h80);
        wr_en = 1; wr_sel = 0; wr_data = 8'hC0; step();
        xfer_done = 1; step();
        chk("R7", "done set", 32'(status[7]), 32'h1);
        chk("R10", "irq with enabled done", 32'(irq), 32'h1);
        // R8: writing 0 at bit 7 keeps the flag; level bits are not touched
        wr_en = 1; wr_sel = 0; wr_data = 8'h7F; step();
        chk("R8", "done kept by zero write", 32'(status[7]), 32'h1);
        wr_en = 1; wr_sel = 0; wr_data = 8'h80; step();
        chk("R8", "done cleared by one write", 32'(status[7]), 32'h0);
        chk("R10", "irq after clear", 32'(irq), 32'h0);
        // R8: a set in the same cycle as a clear wins
        xfer_done = 1; wr_en = 1; wr_sel = 0; wr_data = 8'h80; step();
        chk("R8", "set beats clear", 32'(status[7]), 32'h1);

        // R11: fill transmit side, then flush with contrary indications.
        tx_flush = 1; step();
        for (int k = 0; k < DEPTH; k++) begin tx_push = 1; step(); end
        chk("R4", "tx low mark off when full", 32'(status[1]), 32'h0);
        tx_flush = 1; tx_empty = 0; tx_full = 1; step();
        chk("R11", "tx flush pattern", 32'(status[2:0]), 32'h3);

        // R6 and R12: overfill the receive side, then flush with an overflow event.
        rx_flush = 1; step();
        for (int k = 0; k < DEPTH + 1; k++) begin rx_push = 1; step(); end
        chk("R6", "overflow on push at full", 32'(status[6]), 32'h1);
        chk("R5", "rx high mark", 32'(status[4]), 32'h1);
        rx_flush = 1; ovf_evt = 1; rx_empty = 0; rx_full = 1; step();
        chk("R12", "rx flush clears bits 3..6", 32'(status[6:3]), 32'h0);

        done = 1;
        summary();
        $finish;
    end
endmodule